// File: doc/BRIEF.md
# Maskable Repeating Alarm Comparator

This block holds four alarm fields (seconds, minutes, hours and day of month, each in BCD) and compares them with the running time of day that a separate timekeeper supplies. When the unmasked fields equal the current time, it raises a one-clock interrupt pulse. The top bit of each alarm field is a mask. Only certain patterns of these mask bits are recognised, and the pattern sets how often the alarm repeats: monthly, daily, hourly, every minute, or every second.

Software loads the fields through a byte-wide register port, and each field can be read back through the same port. A write that holds a value which is not a legal BCD number for its field is dropped without notice, so a stored field always holds a value the comparator can use. An interrupt-enable register is only stored and read back, except for its top bit, which gates the pulse. The timekeeper marks each new second with a one-clock time-valid strobe. The compare is made only on that strobe, so there is never more than one pulse per strobe.

Top module: `tod_alarm_unit`

## Requirements
- R1: After reset, the seconds, minutes and hours alarm registers read 0x00, the date alarm register reads 0x01, the enable register reads 0x00, and `alarm_irq` is low.
- R2: Register addresses are 0 = alarm seconds, 1 = alarm minutes, 2 = alarm hours, 3 = alarm date and 4 = interrupt enable. `reg_rdata` shows the full stored byte of the register at `reg_addr` in the same cycle. Any other address reads 0x00, and a write to it changes no register.
- R3: A write to the seconds or minutes alarm register is accepted only if bits 6:4 (tens) and bits 3:0 (units) form a BCD value from 0 to 59, with the units digit at most 9. An accepted write stores all 8 bits, including mask bit 7. The stored byte reads back from the cycle after the write edge.
- R4: A write to the hours alarm register is accepted only if bits 5:4 (tens) and bits 3:0 (units) form a BCD value from 0 to 23, with the units digit at most 9. An accepted write stores all 8 bits.
- R5: A write to the date alarm register is accepted only if bits 5:4 (tens) and bits 3:0 (units) form a nonzero BCD value, with the units digit at most 9. An accepted write stores all 8 bits.
- R6: A write that fails its field's check leaves the stored register unchanged.
- R7: With all four mask bits (bit 7) clear, the alarm matches when seconds, minutes, hours and date all equal the time inputs (monthly repeat).
- R8: With only the date mask set, the alarm matches on equal seconds, minutes and hours, whatever the date (daily repeat).
- R9: With only the date and hours masks set, the alarm matches on equal seconds and minutes (hourly repeat).
- R10: With the date, hours and minutes masks set and the seconds mask clear, the alarm matches on equal seconds (repeat every minute).
- R11: Any other mask pattern matches on every strobe, whatever the time inputs.
- R12: A match is evaluated only in a cycle where `tod_tick` is high. A firing alarm drives `alarm_irq` high for exactly the one cycle after that clock edge. With no strobe, `alarm_irq` stays low even if the time matches.
- R13: The pulse is issued only while bit 7 of the enable register is 1. Bits 6:0 of that register have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Register address for both write and read-back |
| reg_wr | input | 1 | Write strobe for the register at reg_addr |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read-back of the register at reg_addr |
| tod_sec | input | 7 | Current seconds, BCD |
| tod_min | input | 7 | Current minutes, BCD |
| tod_hour | input | 6 | Current hours, BCD |
| tod_date | input | 6 | Current day of month, BCD |
| tod_tick | input | 1 | One-cycle time-valid strobe |
| alarm_irq | output | 1 | One-cycle alarm interrupt pulse |

## Verification
A register write lands at the clock edge that samples `reg_wr`. The bench reads back on the following falling edge, one cycle later, because `reg_rdata` is combinational from the stored byte. A strobe sampled at one rising edge produces its pulse in the cycle that follows. The driver therefore queues the expected pulse value when it raises `tod_tick`, and the monitor removes and compares that value at the next falling edge. On every falling edge that does not follow a strobe, the monitor requires `alarm_irq` to be low.

// File: rtl/tod_alarm_pkg.sv
// Shared constants for the alarm comparator.
// Assumes byte-wide registers and BCD time fields.
package tod_alarm_pkg;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned NUM_FIELDS = 4;
    // Register indices; indices 0..3 are the alarm fields in this order.
    localparam int unsigned REG_SEC  = 0;
    localparam int unsigned REG_MIN  = 1;
    localparam int unsigned REG_HOUR = 2;
    localparam int unsigned REG_DATE = 3;
    localparam int unsigned REG_IEN  = 4;

    // Repeat period picked by the mask pattern.
    typedef enum logic [2:0] {
        RATE_MONTH,
        RATE_DAY,
        RATE_HOUR,
        RATE_MIN,
        RATE_SEC
    } rate_e;
endpackage

// File: rtl/tod_alarm_field.sv
// One alarm field register with BCD write validation.
// Assumes: the value occupies bits VAL_BITS-1:0, with the tens digit above bit 3.
// A write that passes the check stores the whole byte. A failing write is dropped.
module tod_alarm_field
    import tod_alarm_pkg::*;
#(
    parameter int unsigned      VAL_BITS   = 7,
    parameter int unsigned      MAX_VAL    = 59,
    parameter bit               ALLOW_ZERO = 1'b1,
    parameter logic [BYTE_W-1:0] RST_VAL   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] q
);
    localparam int unsigned TENS_W = VAL_BITS - 4;

    logic [TENS_W-1:0] tens;
    logic [3:0]        units;
    logic [6:0]        bin;
    logic              wr_ok;

    // Decode the BCD value and judge whether it is legal for this field.
    always_comb begin
        tens  = wdata[VAL_BITS-1:4];
        units = wdata[3:0];
        bin   = 7'(tens) * 7'd10 + 7'(units);
        wr_ok = (units <= 4'd9) && (bin <= 7'(MAX_VAL)) &&
                (ALLOW_ZERO || (bin != 7'd0));
    end

    // Hold the field; take only validated writes.
    always_ff @(posedge clk) begin
        if (!rst_n)              q <= RST_VAL;
        else if (wr_sel && wr_ok) q <= wdata;
    end

    // R6
    field_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && !wr_ok) |=> $stable(q));
    // R3
    field_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && wr_ok) |=> (q == $past(wdata)));
endmodule

// File: rtl/tod_alarm_regs.sv
// Register bank: four validated alarm fields, an enable byte, and read-back.
// Assumes field index i sits at address i. The enable byte sits at REG_IEN.
module tod_alarm_regs
    import tod_alarm_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic [3:0]        mask,
    output logic [6:0]        a_sec,
    output logic [6:0]        a_min,
    output logic [5:0]        a_hour,
    output logic [5:0]        a_date,
    output logic              ien_on
);
    logic [NUM_FIELDS-1:0][BYTE_W-1:0] fld_q;
    logic [BYTE_W-1:0]                 ien_q;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
        localparam int unsigned      VB = (g < 2) ? 7 : 6;
        localparam int unsigned      MX = (g < 2) ? 59 : ((g == 2) ? 23 : 39);
        localparam bit               AZ = (g != REG_DATE);
        localparam logic [BYTE_W-1:0] RV = (g == REG_DATE) ? 8'h01 : 8'h00;
        tod_alarm_field #(
            .VAL_BITS(VB), .MAX_VAL(MX), .ALLOW_ZERO(AZ), .RST_VAL(RV)
        ) u_fld (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_sel (reg_wr && (reg_addr == ADDR_W'(g))),
            .wdata  (reg_wdata),
            .q      (fld_q[g])
        );
    end

    // Store the enable byte as written.
    always_ff @(posedge clk) begin
        if (!rst_n) ien_q <= '0;
        else if (reg_wr && (reg_addr == ADDR_W'(REG_IEN))) ien_q <= reg_wdata;
    end

    // Select the addressed register for read-back.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_FIELDS; i++)
            if (reg_addr == ADDR_W'(i)) reg_rdata = fld_q[i];
        if (reg_addr == ADDR_W'(REG_IEN)) reg_rdata = ien_q;
    end

    // Split the stored fields into mask bits and compare values.
    always_comb begin
        mask   = {fld_q[REG_DATE][7], fld_q[REG_HOUR][7],
                  fld_q[REG_MIN][7],  fld_q[REG_SEC][7]};
        a_sec  = fld_q[REG_SEC][6:0];
        a_min  = fld_q[REG_MIN][6:0];
        a_hour = fld_q[REG_HOUR][5:0];
        a_date = fld_q[REG_DATE][5:0];
        ien_on = ien_q[7];
    end
endmodule

// File: rtl/tod_alarm_match.sv
// Mask decode and strobe-qualified compare.
// Assumes mask = {date, hour, min, sec}. Registers one pulse per firing strobe.
module tod_alarm_match
    import tod_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] mask,
    input  logic [6:0] a_sec,
    input  logic [6:0] a_min,
    input  logic [5:0] a_hour,
    input  logic [5:0] a_date,
    input  logic       ien_on,
    input  logic [6:0] tod_sec,
    input  logic [6:0] tod_min,
    input  logic [5:0] tod_hour,
    input  logic [5:0] tod_date,
    input  logic       tod_tick,
    output logic       irq
);
    rate_e rate;
    logic  hit;

    // Map the thermometer mask pattern to a repeat period.
    always_comb begin
        unique case (mask)
            4'b0000: rate = RATE_MONTH;
            4'b1000: rate = RATE_DAY;
            4'b1100: rate = RATE_HOUR;
            4'b1110: rate = RATE_MIN;
            default: rate = RATE_SEC;
        endcase
    end

    // Compare only the fields the period leaves unmasked.
    always_comb begin
        hit = 1'b1;
        if (rate != RATE_SEC && a_sec != tod_sec) hit = 1'b0;
        if ((rate == RATE_MONTH || rate == RATE_DAY || rate == RATE_HOUR) &&
            a_min != tod_min) hit = 1'b0;
        if ((rate == RATE_MONTH || rate == RATE_DAY) && a_hour != tod_hour) hit = 1'b0;
        if (rate == RATE_MONTH && a_date != tod_date) hit = 1'b0;
    end

    // Issue a one-cycle pulse for an enabled hit on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= tod_tick && hit && ien_on;
    end

    // R12
    irq_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(tod_tick));
    // R13
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ien_on));
    // R11
    every_sec_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tod_tick && ien_on && mask == 4'b1111) |=> irq);
endmodule

// File: rtl/tod_alarm_unit.sv
// Top: maskable repeating alarm comparator.
// Assumes the time inputs are stable and legal BCD while tod_tick is high.
module tod_alarm_unit
    import tod_alarm_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [6:0]        tod_sec,
    input  logic [6:0]        tod_min,
    input  logic [5:0]        tod_hour,
    input  logic [5:0]        tod_date,
    input  logic              tod_tick,
    output logic              alarm_irq
);
    logic [3:0] mask;
    logic [6:0] a_sec, a_min;
    logic [5:0] a_hour, a_date;
    logic       ien_on;

    tod_alarm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mask      (mask),
        .a_sec     (a_sec),
        .a_min     (a_min),
        .a_hour    (a_hour),
        .a_date    (a_date),
        .ien_on    (ien_on)
    );

    tod_alarm_match u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask     (mask),
        .a_sec    (a_sec),
        .a_min    (a_min),
        .a_hour   (a_hour),
        .a_date   (a_date),
        .ien_on   (ien_on),
        .tod_sec  (tod_sec),
        .tod_min  (tod_min),
        .tod_hour (tod_hour),
        .tod_date (tod_date),
        .tod_tick (tod_tick),
        .irq      (alarm_irq)
    );
endmodule

// File: tb/tod_alarm_unit_test.sv
`timescale 1ns/1ps
module tod_alarm_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [6:0] tod_sec = '0, tod_min = '0;
    logic [5:0] tod_hour = '0, tod_date = '0;
    logic       tod_tick = 1'b0;
    logic       alarm_irq;

    always #2.5 clk = ~clk;

    tod_alarm_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tod_sec(tod_sec),
        .tod_min(tod_min), .tod_hour(tod_hour), .tod_date(tod_date),
        .tod_tick(tod_tick), .alarm_irq(alarm_irq)
    );

    int checks = 0;
    int fails  = 0;
    logic [7:0] sh [5];
    bit    exp_q[$];
    string tag_q[$];
    bit    sampled_tick = 1'b0;

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    function automatic bit legal(input int a, input logic [7:0] v);
        int u = v[3:0];
        case (a)
            0, 1: return (u <= 9) && (v[6:4] * 10 + u <= 59);
            2:    return (u <= 9) && (v[5:4] * 10 + u <= 23);
            3:    return (u <= 9) && (v[5:4] * 10 + u != 0);
            4:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit fire_exp(input logic [6:0] ts, input logic [6:0] tm,
                                    input logic [5:0] th, input logic [5:0] td);
        logic [3:0] mk = {sh[3][7], sh[2][7], sh[1][7], sh[0][7]};
        logic [3:0] c;
        case (mk)
            4'b0000: c = 4'b1111;
            4'b1000: c = 4'b0111;
            4'b1100: c = 4'b0011;
            4'b1110: c = 4'b0001;
            default: c = 4'b0000;
        endcase
        return sh[4][7] && (!c[0] || sh[0][6:0] == ts) && (!c[1] || sh[1][6:0] == tm)
               && (!c[2] || sh[2][5:0] == th) && (!c[3] || sh[3][5:0] == td);
    endfunction

    task automatic wr(input int a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = 3'(a); reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a <= 4 && legal(a, v)) sh[a] = v;
    endtask

    task automatic rd(input int a, input string tag);
        reg_addr = 3'(a);
        #1;
        chk(tag, reg_rdata, (a <= 4) ? sh[a] : 8'h00);
    endtask

    task automatic tk(input logic [6:0] ts, input logic [6:0] tm,
                      input logic [5:0] th, input logic [5:0] td, input string tag);
        @(negedge clk);
        tod_sec = ts; tod_min = tm; tod_hour = th; tod_date = td; tod_tick = 1'b1;
        exp_q.push_back(fire_exp(ts, tm, th, td));
        tag_q.push_back(tag);
        @(negedge clk);
        tod_tick = 1'b0;
    endtask

    // Monitor: capture strobes, then compare the pulse one cycle later.
    always @(posedge clk) sampled_tick <= tod_tick;

    always @(negedge clk) begin
        bit    e;
        string t;
        if (rst_n) begin
            if (sampled_tick && exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, {7'd0, alarm_irq}, {7'd0, e});
            end else if (!sampled_tick) begin
                chk("R12 no pulse without strobe", {7'd0, alarm_irq}, 8'h00);
            end
        end
    end

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        sh[0] = 8'h00; sh[1] = 8'h00; sh[2] = 8'h00; sh[3] = 8'h01; sh[4] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", {7'd0, alarm_irq}, 8'h00);
        rst_n = 1'b1;
        for (int a = 0; a < 5; a++) rd(a, "R1 reset value");

        // Seconds and minutes validation
        wr(0, 8'h45); rd(0, "R3 sec accept");
        wr(0, 8'h60); rd(0, "R6 sec 60 rejected");
        wr(0, 8'h3A); rd(0, "R6 sec bad units rejected");
        wr(0, 8'hD9); rd(0, "R3 sec with mask bit");
        wr(1, 8'h59); rd(1, "R3 min accept");
        wr(1, 8'h7F); rd(1, "R6 min rejected");
        // Hours
        wr(2, 8'h23); rd(2, "R4 hour 23 accept");
        wr(2, 8'h24); rd(2, "R6 hour 24 rejected");
        wr(2, 8'h1A); rd(2, "R6 hour bad units rejected");
        wr(2, 8'hD2); rd(2, "R4 hour upper bits stored");
        // Date
        wr(3, 8'h00); rd(3, "R6 date zero rejected");
        wr(3, 8'h40); rd(3, "R6 date zero value rejected");
        wr(3, 8'h31); rd(3, "R5 date accept");
        wr(3, 8'h3A); rd(3, "R6 date bad units rejected");
        // Unmapped addresses
        wr(5, 8'h55);
        for (int a = 0; a < 8; a++) rd(a, "R2 map after unmapped write");
        wr(4, 8'h80); rd(4, "R2 enable readback");

        // Monthly
        wr(0, 8'h30); wr(1, 8'h15); wr(2, 8'h08); wr(3, 8'h12);
        tk(7'h30, 7'h15, 6'h08, 6'h12, "R7 monthly match");
        tk(7'h30, 7'h15, 6'h08, 6'h13, "R7 date differs");
        tk(7'h31, 7'h15, 6'h08, 6'h12, "R7 sec differs");
        tk(7'h30, 7'h16, 6'h08, 6'h12, "R7 min differs");
        // No strobe: matching time held, monitor expects low
        @(negedge clk);
        tod_sec = 7'h30; tod_min = 7'h15; tod_hour = 6'h08; tod_date = 6'h12;
        repeat (4) @(negedge clk);
        // Daily
        wr(3, 8'h92);
        tk(7'h30, 7'h15, 6'h08, 6'h05, "R8 daily any date");
        tk(7'h30, 7'h15, 6'h09, 6'h12, "R8 hour differs");
        // Hourly
        wr(2, 8'h88);
        tk(7'h30, 7'h15, 6'h21, 6'h05, "R9 hourly any hour");
        tk(7'h30, 7'h17, 6'h08, 6'h12, "R9 min differs");
        // Every minute
        wr(1, 8'h95);
        tk(7'h30, 7'h44, 6'h21, 6'h05, "R10 minute any min");
        tk(7'h31, 7'h15, 6'h08, 6'h12, "R10 sec differs");
        // Every second
        wr(0, 8'hB0);
        tk(7'h07, 7'h01, 6'h02, 6'h03, "R11 all masks");
        tk(7'h08, 7'h01, 6'h02, 6'h03, "R12 back-to-back strobe");
        wr(1, 8'h15);
        tk(7'h01, 7'h02, 6'h03, 6'h04, "R11 pattern 1101");
        wr(3, 8'h12); wr(2, 8'h08);
        tk(7'h59, 7'h59, 6'h23, 6'h31, "R11 sec mask only");
        // Enable gating
        wr(4, 8'h7F); rd(4, "R13 enable low bits stored");
        tk(7'h59, 7'h59, 6'h23, 6'h31, "R13 disabled");
        wr(4, 8'h80);
        tk(7'h00, 7'h00, 6'h00, 6'h01, "R13 enabled");

        repeat (3) @(negedge clk);
        chk("R12 queue drained", 8'(exp_q.size()), 8'h00);
        summary();
    end
endmodule